// File: doc/BRIEF.md
# ADC Parallel Output Capture Decoder

This block sits at the pins of a pipelined analog-to-digital converter that presents each conversion as a parallel word, with an over/under-range flag and a data-valid clock that toggles once per sample. On each rising edge of that clock the block takes in the word and the flag. When the converter has scrambled its outputs to reduce digital interference, the block undoes the scrambling. It then turns the sample into a signed two's-complement value, whichever output coding the converter's mode strap selected.

The results are a registered signed sample, a registered range flag, a one-cycle valid strobe for every accepted sample, and a saturating count of the accepted samples that were out of range. A drive-enable input marks the periods when the converter's outputs are floating, because it is shut down or its outputs are disabled. No sample is accepted during those periods. Everything runs in the converter's data-valid clock domain.

Top module: `adc_capture_decoder`

## Requirements
- R1: `sample_o` is a signed two's-complement word whose bit 15 is the most significant bit.
- R2: When `rand_en_i` is 1, each of input bits 15..1 is XORed with received bit 0 before format conversion. When `rand_en_i` is 0, no bit is changed.
- R3: Sample bit 0 passes to `sample_o[0]` unchanged in every mode.
- R4: For `fmt_mode_i` = 2'b00 or 2'b11, the input is offset binary. The output is the de-scrambled word with bit 15 inverted (0x8000 gives 0x0000, 0x0000 gives 0x8000, 0xFFFF gives 0x7FFF).
- R5: For `fmt_mode_i` = 2'b01 or 2'b10, the input is already two's complement and the de-scrambled word is passed through unchanged.
- R6: The word and flag are captured on the rising edge of `clk_i` when `drive_en_i` is 1. The results appear on the outputs after exactly one register stage, and `valid_o` is 1 for that one cycle.
- R7: `ovr_o` is `adc_ovr_i` registered together with the sample it belongs to.
- R8: While `drive_en_i` is 0, no sample is accepted. `valid_o` is 0 on the following cycle, `sample_o` and `ovr_o` hold their previous values, and `ovr_count_o` does not change.
- R9: `ovr_count_o` increases by one for each accepted sample whose `adc_ovr_i` is 1. It stops at 0xFFFF.
- R10: While `rst_i` is 1 at a clock edge, every output is 0 after that edge, including the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter data-valid clock; capture on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| adc_word_i | input | 16 | Parallel sample word from the converter |
| adc_ovr_i | input | 1 | Over/under-range flag from the converter |
| rand_en_i | input | 1 | 1 when the converter's output scrambling is on |
| fmt_mode_i | input | 2 | Four-level mode strap code: 00/11 offset binary, 01/10 two's complement |
| drive_en_i | input | 1 | 1 while the converter is powered and driving its outputs |
| sample_o | output | 16 | Signed two's-complement sample |
| ovr_o | output | 1 | Registered range flag of the current sample |
| valid_o | output | 1 | One-cycle strobe per accepted sample |
| ovr_count_o | output | 16 | Saturating count of out-of-range samples |

## Verification
The assertions check on every cycle the relationships between successive edges. Each enable produces one strobe the next cycle and each gap produces none. Bit 0 and the range flag follow their inputs by one stage, and the sign bit matches the scrambling and mode inputs. Sample and counter hold through gaps, and the counter steps by one or stays pinned at its ceiling. Only the bench's scenarios can show that whole words are decoded correctly: the extreme codes in both formats, scrambled words with either value of bit 0, and all four strap codes. They also show that the counter reaches and keeps its ceiling after tens of thousands of events, and that a reset in the middle of a run clears it.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

   // Strap levels from lowest to highest; the outer two share a coding.
   typedef enum logic [1:0] {
      STRAP_LVL0 = 2'b00,
      STRAP_LVL1 = 2'b01,
      STRAP_LVL2 = 2'b10,
      STRAP_LVL3 = 2'b11
   } strap_lvl_e;

   function automatic logic strap_is_offset(input logic [1:0] lvl);
      return (lvl == STRAP_LVL0) || (lvl == STRAP_LVL3);
   endfunction

endpackage

// File: rtl/adc_derand.sv
module adc_derand #(
   parameter int WORD_W = 16
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic              en_i,
   output logic [WORD_W-1:0] word_o
);

   if (WORD_W < 2) begin : g_bad_width
      $error("adc_derand: WORD_W must be at least 2");
   end

   logic key;
   assign key = en_i & word_i[0];

   for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      if (b == 0) begin : g_lsb
         assign word_o[b] = word_i[b];
      end else begin : g_upper
         assign word_o[b] = word_i[b] ^ key;
      end
   end

endmodule

// File: rtl/adc_fmt_norm.sv
module adc_fmt_norm
   import adc_cap_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [1:0]        lvl_i,
   output logic [WORD_W-1:0] word_o
);

   if (WORD_W < 2) begin : g_bad_width
      $error("adc_fmt_norm: WORD_W must be at least 2");
   end

   logic flip_msb;
   assign flip_msb = strap_is_offset(lvl_i);

   always_comb begin
      word_o           = word_i;
      word_o[WORD_W-1] = word_i[WORD_W-1] ^ flip_msb;
   end

endmodule

// File: rtl/adc_ovr_counter.sv
module adc_ovr_counter #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] count_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (CNT_W < 1) begin : g_bad_width
      $error("adc_ovr_counter: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             step;

   if (SATURATE) begin : g_sat
      assign step = inc_i && (cnt_q != CNT_MAX);
   end else begin : g_wrap
      assign step = inc_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= cnt_q + CNT_ONE;
      end
   end

   assign count_o = cnt_q;

endmodule

// File: rtl/adc_capture_decoder.sv
module adc_capture_decoder #(
   parameter int WORD_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [WORD_W-1:0] adc_word_i,
   input  logic              adc_ovr_i,
   input  logic              rand_en_i,
   input  logic [1:0]        fmt_mode_i,
   input  logic              drive_en_i,
   output logic [WORD_W-1:0] sample_o,
   output logic              ovr_o,
   output logic              valid_o,
   output logic [CNT_W-1:0]  ovr_count_o
);

   if (WORD_W < 2) begin : g_bad_word
      $error("adc_capture_decoder: WORD_W must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("adc_capture_decoder: CNT_W must be at least 1");
   end

   logic [WORD_W-1:0] plain_word;
   logic [WORD_W-1:0] signed_word;
   logic [WORD_W-1:0] sample_q;
   logic              ovr_q;
   logic              valid_q;
   logic              accept;

   assign accept = drive_en_i;

   adc_derand #(.WORD_W(WORD_W)) u_derand (
      .word_i (adc_word_i),
      .en_i   (rand_en_i),
      .word_o (plain_word)
   );

   adc_fmt_norm #(.WORD_W(WORD_W)) u_fmt (
      .word_i (plain_word),
      .lvl_i  (fmt_mode_i),
      .word_o (signed_word)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sample_q <= '0;
         ovr_q    <= 1'b0;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= accept;
         if (accept) begin
            sample_q <= signed_word;
            ovr_q    <= adc_ovr_i;
         end
      end
   end

   adc_ovr_counter #(.CNT_W(CNT_W), .SATURATE(1'b1)) u_cnt (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .inc_i   (accept & adc_ovr_i),
      .count_o (ovr_count_o)
   );

   assign sample_o = sample_q;
   assign ovr_o    = ovr_q;
   assign valid_o  = valid_q;

endmodule

// File: rtl/adc_capture_decoder_chk.sv
module adc_capture_decoder_chk #(
   parameter int WORD_W = 16,
   parameter int CNT_W  = 16
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic [WORD_W-1:0] adc_word_i,
   input logic              adc_ovr_i,
   input logic              rand_en_i,
   input logic [1:0]        fmt_mode_i,
   input logic              drive_en_i,
   input logic [WORD_W-1:0] sample_o,
   input logic              ovr_o,
   input logic              valid_o,
   input logic [CNT_W-1:0]  ovr_count_o
);

   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   AST_STROBE_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (rst_i)
      drive_en_i |=> valid_o); // R6

   AST_NO_STROBE_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
      !drive_en_i |=> !valid_o); // R8

   AST_LSB_THROUGH: assert property (@(posedge clk_i) disable iff (rst_i)
      drive_en_i |=> sample_o[0] == $past(adc_word_i[0])); // R3

   AST_SIGN_BIT: assert property (@(posedge clk_i) disable iff (rst_i)
      drive_en_i |=> sample_o[WORD_W-1] == $past(adc_word_i[WORD_W-1]
         ^ (rand_en_i & adc_word_i[0]) ^ (fmt_mode_i[1] == fmt_mode_i[0]))); // R4

   AST_FLAG_FOLLOWS: assert property (@(posedge clk_i) disable iff (rst_i)
      drive_en_i |=> ovr_o == $past(adc_ovr_i)); // R7

   AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
      !drive_en_i |=> $stable(sample_o) && $stable(ovr_o)); // R8

   AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
      (drive_en_i && adc_ovr_i && ovr_count_o != TOP)
      |=> ovr_count_o == $past(ovr_count_o) + CNT_W'(1)); // R9

   AST_COUNT_STILL: assert property (@(posedge clk_i) disable iff (rst_i)
      !(drive_en_i && adc_ovr_i) |=> $stable(ovr_count_o)); // R9

   AST_COUNT_CEILING: assert property (@(posedge clk_i) disable iff (rst_i)
      ovr_count_o == TOP |=> ovr_count_o == TOP); // R9

   AST_RESET_CLEAR: assert property (@(posedge clk_i)
      rst_i |=> (sample_o == '0) && !ovr_o && !valid_o && (ovr_count_o == '0)); // R10

endmodule

bind adc_capture_decoder adc_capture_decoder_chk #(
   .WORD_W(WORD_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_i       (rst_i),
   .adc_word_i  (adc_word_i),
   .adc_ovr_i   (adc_ovr_i),
   .rand_en_i   (rand_en_i),
   .fmt_mode_i  (fmt_mode_i),
   .drive_en_i  (drive_en_i),
   .sample_o    (sample_o),
   .ovr_o       (ovr_o),
   .valid_o     (valid_o),
   .ovr_count_o (ovr_count_o)
);

// File: tb/adc_capture_decoder_test.sv
module adc_capture_decoder_test;

   logic        clk_i = 1'b0;
   logic        rst_i;
   logic [15:0] adc_word_i;
   logic        adc_ovr_i;
   logic        rand_en_i;
   logic [1:0]  fmt_mode_i;
   logic        drive_en_i;
   logic [15:0] sample_o;
   logic        ovr_o;
   logic        valid_o;
   logic [15:0] ovr_count_o;

   int checks = 0;
   int errors = 0;

   always #5 clk_i = ~clk_i;

   adc_capture_decoder uut (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .adc_word_i  (adc_word_i),
      .adc_ovr_i   (adc_ovr_i),
      .rand_en_i   (rand_en_i),
      .fmt_mode_i  (fmt_mode_i),
      .drive_en_i  (drive_en_i),
      .sample_o    (sample_o),
      .ovr_o       (ovr_o),
      .valid_o     (valid_o),
      .ovr_count_o (ovr_count_o)
   );

   // {word, rand, mode, ovr, expected sample, requirement}
   localparam int NV = 10;
   localparam logic [35:0] VEC [NV] = '{
      {16'h8000, 1'b0, 2'b00, 1'b0, 16'h0000},  // R4 mid-scale
      {16'h0000, 1'b0, 2'b00, 1'b0, 16'h8000},  // R4 bottom
      {16'hFFFF, 1'b0, 2'b11, 1'b1, 16'h7FFF},  // R4 top, upper strap
      {16'h1234, 1'b0, 2'b01, 1'b0, 16'h1234},  // R5
      {16'h8001, 1'b0, 2'b10, 1'b0, 16'h8001},  // R5 R1 negative
      {16'hEDCB, 1'b1, 2'b01, 1'b0, 16'h1235},  // R2 key=1
      {16'h8000, 1'b1, 2'b00, 1'b0, 16'h0000},  // R2 key=0
      {16'h0001, 1'b1, 2'b11, 1'b1, 16'h7FFF},  // R2 with R4
      {16'hFFFF, 1'b1, 2'b10, 1'b0, 16'h0001},  // R2 R3
      {16'h7FFF, 1'b0, 2'b01, 1'b1, 16'h7FFF}   // R1 R5 max positive
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_i      = 1'b1;
      adc_word_i = 16'hABCD;
      adc_ovr_i  = 1'b1;
      rand_en_i  = 1'b0;
      fmt_mode_i = 2'b01;
      drive_en_i = 1'b1;
      repeat (3) @(negedge clk_i);
      check("R10 sample in reset", 32'(sample_o), 32'h0);
      check("R10 valid in reset", 32'(valid_o), 32'h0);
      check("R10 ovr in reset", 32'(ovr_o), 32'h0);
      check("R10 count in reset", 32'(ovr_count_o), 32'h0);
      rst_i = 1'b0;

      for (int i = 0; i < NV; i++) begin
         {adc_word_i, rand_en_i, fmt_mode_i, adc_ovr_i} = VEC[i][35:16];
         @(negedge clk_i);
         check($sformatf("R1 R2 R4 R5 vector %0d", i), 32'(sample_o), 32'(VEC[i][15:0]));
         check($sformatf("R6 strobe vector %0d", i), 32'(valid_o), 32'h1);
         check($sformatf("R7 flag vector %0d", i), 32'(ovr_o), 32'(VEC[i][16]));
      end
      check("R9 count after table", 32'(ovr_count_o), 32'd3);

      // R8: gap with a different word and the flag set
      drive_en_i = 1'b0;
      adc_word_i = 16'h5555;
      adc_ovr_i  = 1'b1;
      @(negedge clk_i);
      check("R8 no strobe", 32'(valid_o), 32'h0);
      check("R8 sample held", 32'(sample_o), 32'h7FFF);
      check("R8 count held", 32'(ovr_count_o), 32'd3);
      @(negedge clk_i);
      check("R8 still held", 32'(sample_o), 32'h7FFF);

      drive_en_i = 1'b1;
      adc_ovr_i  = 1'b0;
      adc_word_i = 16'h4000;
      rand_en_i  = 1'b0;
      fmt_mode_i = 2'b01;
      @(negedge clk_i);
      check("R6 resumed sample", 32'(sample_o), 32'h4000);
      check("R6 resumed strobe", 32'(valid_o), 32'h1);
      check("R7 flag cleared", 32'(ovr_o), 32'h0);
      check("R9 no count without flag", 32'(ovr_count_o), 32'd3);

      // R9 saturation
      adc_ovr_i = 1'b1;
      repeat (65532) @(negedge clk_i);
      check("R9 reaches ceiling", 32'(ovr_count_o), 32'hFFFF);
      repeat (5) @(negedge clk_i);
      check("R9 stays at ceiling", 32'(ovr_count_o), 32'hFFFF);

      // R10 reset in the middle of a run
      rst_i = 1'b1;
      @(negedge clk_i);
      check("R10 count cleared", 32'(ovr_count_o), 32'h0);
      check("R10 sample cleared", 32'(sample_o), 32'h0);
      check("R10 strobe cleared", 32'(valid_o), 32'h0);
      rst_i = 1'b0;
      @(negedge clk_i);
      check("R9 count restarts", 32'(ovr_count_o), 32'd1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule